// File: doc/BRIEF.md
# Event Timer Main Counter and Global Registers

This block is the shared front end of a multi-channel event timer. It holds a free-running 64-bit tick counter, a read-only capability word, a global configuration register and a per-channel interrupt status register. Software reaches these registers through a simple 32-bit register port that uses byte addresses inside a 1 KiB window. The per-channel registers live in the same window. They are not stored here. Instead the block decodes them into a channel index, a sub-offset and read/write strobes, and returns the read data that the selected channel block supplies.

The channel comparators sit outside this block and report their events on per-channel status-set inputs. When software clears a status bit, the block emits a one-cycle clear pulse for that channel, which the interrupt driver uses to drop its line. The counter is held at its current value while the global enable is off and carries on from that value when the enable is set again. Either 32-bit half of the counter may be loaded at any time.

Top module: `evt_timer_global`

## Requirements
- R1: After reset the counter, the global configuration and the status register are all zero, and `glb_enable`, `legacy_route` and `irq_clr` are low.
- R2: Offset 0x000 reads 0x8086A001 with (channel count − 1) placed in bits 12:8, so the default of three channels reads 0x8086A201. Offset 0x004 reads the tick period in femtoseconds. Writes to either offset change nothing.
- R3: Offset 0x010 holds the enable in bit 0 and the legacy-route flag in bit 1, which drive `glb_enable` and `legacy_route`. Its other bits read zero. Offset 0x014 reads zero and ignores writes.
- R4: While enabled and not being written, the counter rises by one on every clock, with the carry passing from the low half into the high half.
- R5: While the enable is clear the counter holds its value. Setting the enable again resumes counting from the held value.
- R6: A write to 0x0F0 loads the low 32 bits and a write to 0x0F4 loads the high 32 bits, whether or not the counter is enabled. The new value appears on the next clock, and counting continues from it.
- R7: A read strobe returns its data on `reg_rdata` with `reg_rvalid` high on the following cycle. A counter read returns the live count as it stood in the cycle of the strobe.
- R8: Offset 0x020 reads the status bits, with channel n at bit n. Writing it clears only the bits that are written as 1 and are currently set. For each bit cleared, `irq_clr` gives a pulse of one cycle in the cycle after the write.
- R9: A status-set input sets its bit only while the global enable is on. If a set and a clear hit the same bit in the same cycle, the set wins and no clear pulse is given for that bit.
- R10: Addresses 0x100 to 0x3FF select channel (addr − 0x100) / 32, with sub-offset addr[4:0]. The write and read strobes, the write data and the index are passed to the channel blocks, and `ch_rdata` is returned as the read data.
- R11: A channel index at or above the implemented count gives no channel strobe and reads zero. The count is the parameter clamped to a minimum of 3 and a maximum of `MAX_TIMERS`.
- R12: Any other global offset reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| ch_wr | output | 1 | Write strobe to the selected channel |
| ch_rd | output | 1 | Read strobe to the selected channel |
| ch_idx | output | 5 | Selected channel index |
| ch_off | output | 5 | Byte sub-offset inside the channel's registers |
| ch_wdata | output | 32 | Write data forwarded to the channels |
| ch_rdata | input | 32 | Read data from the selected channel |
| sts_set | input | NT | Per-channel status-set events |
| irq_clr | output | NT | Per-channel interrupt clear pulses |
| glb_enable | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy routing flag |
| main_count | output | 64 | Current counter value |

## Verification
Assertions run on every cycle and check the counter's behaviour: it steps by exactly one while enabled, stays still while disabled, and takes in a written half on the following clock. They also check that a status write leaves no written bit set unless a set event arrived in the same cycle, that no new status bit appears while disabled, that clear pulses name only bits that were set, that the read-valid timing holds, and that channel strobes fire only for implemented channels. Some behaviours can only be shown by the bench's scenarios. These are the exact capability encoding, the count held across a disable and resumed across a re-enable, the live value returned in the middle of a count, the carry from the low half into the high half, the set-beats-clear collision, and the zero returned for absent channels and unmapped offsets.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W       = 10;
  localparam int MIN_TIMERS   = 3;
  localparam int CH_SHIFT     = 5;
  localparam logic [ADDR_W-1:0] CH_BASE = 10'h100;

  typedef enum logic [2:0] {
    G_NONE, G_CAP_LO, G_CAP_HI, G_CFG, G_STS, G_CNT_LO, G_CNT_HI
  } greg_e;
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_pkg::*;
#(
  parameter int NT    = 3,
  parameter int IDX_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_ch,
  output logic              ch_ok,
  output logic [IDX_W-1:0]  ch_idx,
  output logic [4:0]        ch_off,
  output greg_e             greg
);
  logic [ADDR_W-1:0] rel;

  always_comb begin
    is_ch  = (addr >= CH_BASE);
    rel    = addr - CH_BASE;
    ch_idx = IDX_W'(rel >> CH_SHIFT);
    ch_off = addr[4:0];
    ch_ok  = is_ch && (int'(ch_idx) < NT);
    greg   = G_NONE;
    if (!is_ch) begin
      unique case ({addr[ADDR_W-1:2], 2'b00})
        10'h000: greg = G_CAP_LO;
        10'h004: greg = G_CAP_HI;
        10'h010: greg = G_CFG;
        10'h020: greg = G_STS;
        10'h0F0: greg = G_CNT_LO;
        10'h0F4: greg = G_CNT_HI;
        default: greg = G_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt
);
  localparam int HI_W = CW - 32;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt <= {cnt[CW-1:32], wdata};
    end else if (wr_hi) begin
      cnt <= {wdata[HI_W-1:0], cnt[31:0]};
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (en && !wr_lo && !wr_hi) |=> cnt == $past(cnt) + 1'b1);
  assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_lo && !wr_hi) |=> $stable(cnt));
  assert_load_lo_R6: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> cnt[31:0] == $past(wdata));
endmodule

// File: rtl/evt_status.sv
module evt_status #(
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [NT-1:0] set,
  input  logic          clr_wr,
  input  logic [NT-1:0] clr_mask,
  output logic [NT-1:0] sts,
  output logic [NT-1:0] irq_clr
);
  logic [NT-1:0] set_g, clr_eff;

  always_comb begin
    set_g   = en ? set : '0;
    clr_eff = clr_wr ? (clr_mask & sts & ~set_g) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts     <= '0;
      irq_clr <= '0;
    end else begin
      sts     <= (sts & ~clr_eff) | set_g;
      irq_clr <= clr_eff;
    end
  end

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (sts & $past(clr_mask & ~set)) == '0);
  assert_clr_only_set_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_clr & ~$past(sts)) == '0);
  assert_noset_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sts & ~$past(sts)) == '0);
endmodule

// File: rtl/evt_timer_global.sv
module evt_timer_global
  import evt_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter int          MAX_TIMERS = 24,
  parameter logic [31:0] TICK_FS    = 32'd8000000,
  localparam int NT = (NUM_TIMERS < MIN_TIMERS) ? MIN_TIMERS :
                      ((NUM_TIMERS > MAX_TIMERS) ? MAX_TIMERS : NUM_TIMERS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [9:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          reg_rvalid,
  output logic          ch_wr,
  output logic          ch_rd,
  output logic [4:0]    ch_idx,
  output logic [4:0]    ch_off,
  output logic [31:0]   ch_wdata,
  input  logic [31:0]   ch_rdata,
  input  logic [NT-1:0] sts_set,
  output logic [NT-1:0] irq_clr,
  output logic          glb_enable,
  output logic          legacy_route,
  output logic [63:0]   main_count
);
  localparam int          IDX_W  = 5;
  localparam logic [31:0] CAP_LO = 32'h8086A001 | (32'(NT - 1) << 8);

  logic        is_ch, ch_ok;
  greg_e       greg;
  logic [1:0]  cfg_q;
  logic [NT-1:0] sts;
  logic [31:0] rd_mux;

  evt_addr_decode #(.NT(NT), .IDX_W(IDX_W)) u_dec (
    .addr(reg_addr), .is_ch(is_ch), .ch_ok(ch_ok),
    .ch_idx(ch_idx), .ch_off(ch_off), .greg(greg)
  );

  evt_main_counter #(.CW(64)) u_cnt (
    .clk(clk), .rst(rst), .en(cfg_q[0]),
    .wr_lo(reg_wr && greg == G_CNT_LO),
    .wr_hi(reg_wr && greg == G_CNT_HI),
    .wdata(reg_wdata), .cnt(main_count)
  );

  evt_status #(.NT(NT)) u_sts (
    .clk(clk), .rst(rst), .en(cfg_q[0]), .set(sts_set),
    .clr_wr(reg_wr && greg == G_STS), .clr_mask(reg_wdata[NT-1:0]),
    .sts(sts), .irq_clr(irq_clr)
  );

  assign ch_wr        = reg_wr && ch_ok;
  assign ch_rd        = reg_rd && ch_ok;
  assign ch_wdata     = reg_wdata;
  assign glb_enable   = cfg_q[0];
  assign legacy_route = cfg_q[1];

  always_ff @(posedge clk) begin
    if (rst)                         cfg_q <= '0;
    else if (reg_wr && greg == G_CFG) cfg_q <= reg_wdata[1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (is_ch) begin
      if (ch_ok) rd_mux = ch_rdata;
    end else begin
      unique case (greg)
        G_CAP_LO: rd_mux = CAP_LO;
        G_CAP_HI: rd_mux = TICK_FS;
        G_CFG:    rd_mux = {30'd0, cfg_q};
        G_STS:    rd_mux = 32'(sts);
        G_CNT_LO: rd_mux = main_count[31:0];
        G_CNT_HI: rd_mux = main_count[63:32];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  assert_rvalid_R7: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr[9:2] == 8'h04) |=> glb_enable == $past(reg_wdata[0]));
  assert_chan_range_R11: assert property (@(posedge clk) disable iff (rst)
    (ch_wr || ch_rd) |-> (reg_addr >= 10'h100 &&
      int'((reg_addr - 10'h100) >> 5) < NT));
endmodule

// File: tb/evt_timer_global_tb.sv
module evt_timer_global_tb;
  localparam int NT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        ch_wr, ch_rd;
  logic [4:0]  ch_idx, ch_off;
  logic [31:0] ch_wdata, ch_rdata;
  logic [NT-1:0] sts_set = '0;
  logic [NT-1:0] irq_clr;
  logic        glb_enable, legacy_route;
  logic [63:0] main_count;

  always #4 clk = ~clk;

  assign ch_rdata = 32'hC0DE0000 | {22'd0, ch_idx, ch_off};

  evt_timer_global u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ch_wr(ch_wr), .ch_rd(ch_rd), .ch_idx(ch_idx),
    .ch_off(ch_off), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
    .sts_set(sts_set), .irq_clr(irq_clr), .glb_enable(glb_enable),
    .legacy_route(legacy_route), .main_count(main_count)
  );

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      if (sbq.size() == 0) chk("R7 unexpected rvalid", 1, 0);
      else begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, reg_rdata, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // tasks are called at a negedge and return at the next one
  task automatic wr(logic [9:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] e, string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 enable", glb_enable, 0);
    chk("R1 legacy", legacy_route, 0);
    chk("R1 irq_clr", irq_clr, 0);
    rd(10'h0F0, 32'h0, "R1 counter lo");
    rd(10'h010, 32'h0, "R1 config");
    rd(10'h020, 32'h0, "R1 status");
    // R2 capability
    rd(10'h000, 32'h8086A201, "R2 cap lo");
    rd(10'h004, 32'd8000000, "R2 cap hi");
    wr(10'h000, 32'h0);
    wr(10'h004, 32'h0);
    rd(10'h000, 32'h8086A201, "R2 cap lo after write");
    rd(10'h004, 32'd8000000, "R2 cap hi after write");
    // R3 configuration
    wr(10'h010, 32'hFFFF_FFFE);
    chk("R3 legacy set", legacy_route, 1);
    chk("R3 enable clear", glb_enable, 0);
    rd(10'h010, 32'h2, "R3 config masked");
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014, 32'h0, "R3 config hi");
    wr(10'h010, 32'h0);
    // R12 unmapped global offset
    wr(10'h040, 32'h1234_5678);
    rd(10'h040, 32'h0, "R12 unmapped");
    chk("R12 no effect on counter", main_count, 0);
    // R5 freeze and resume
    wr(10'h010, 32'h1);
    idle(5);
    wr(10'h010, 32'h0);
    idle(3);
    rd(10'h0F0, 32'd6, "R5 frozen value");
    wr(10'h010, 32'h1);
    wr(10'h010, 32'h0);
    rd(10'h0F0, 32'd7, "R5 resumed from frozen");
    // R7 live read, R4 steady count
    wr(10'h010, 32'h1);
    rd(10'h0F0, 32'd7, "R7 live read at enable");
    idle(3);
    rd(10'h0F0, 32'd11, "R4 count after steps");
    // R6 write while enabled
    wr(10'h0F0, 32'h100);
    rd(10'h0F0, 32'h100, "R6 written lo");
    rd(10'h0F0, 32'h101, "R6 continues from written");
    wr(10'h010, 32'h0);
    // R4 carry into high half
    wr(10'h0F0, 32'hFFFF_FFFF);
    wr(10'h0F4, 32'h0);
    chk("R6 load while disabled", main_count, 64'h0000_0000_FFFF_FFFF);
    wr(10'h010, 32'h1);
    rd(10'h0F0, 32'hFFFF_FFFF, "R4 before carry");
    rd(10'h0F4, 32'h1, "R4 carry into hi");
    rd(10'h0F0, 32'h1, "R4 lo after carry");
    // R8 status W1C
    sts_set = 3'b011;
    @(negedge clk);
    sts_set = '0;
    rd(10'h020, 32'h3, "R8 status set");
    wr(10'h020, 32'h5);
    chk("R8 clear pulse", irq_clr, 3'b001);
    rd(10'h020, 32'h2, "R8 status after w1c");
    chk("R8 pulse one cycle", irq_clr, 3'b000);
    // R9 set beats clear
    sts_set = 3'b010;
    wr(10'h020, 32'h2);
    sts_set = '0;
    chk("R9 no pulse on collision", irq_clr, 3'b000);
    rd(10'h020, 32'h2, "R9 set wins");
    wr(10'h020, 32'h2);
    chk("R8 clear pulse bit1", irq_clr, 3'b010);
    rd(10'h020, 32'h0, "R8 status empty");
    // R9 no set while disabled
    wr(10'h010, 32'h0);
    sts_set = 3'b111;
    @(negedge clk);
    sts_set = '0;
    rd(10'h020, 32'h0, "R9 ignored while disabled");
    // R10 channel decode
    reg_wr = 1'b1; reg_addr = 10'h148; reg_wdata = 32'hA5A5_0001;
    #1;
    chk("R10 ch_wr", ch_wr, 1);
    chk("R10 ch_idx", ch_idx, 2);
    chk("R10 ch_off", ch_off, 8);
    chk("R10 ch_wdata", ch_wdata, 32'hA5A5_0001);
    @(negedge clk);
    reg_wr = 1'b0;
    rd(10'h130, 32'hC0DE0030, "R10 channel read");
    // R11 absent channel
    reg_wr = 1'b1; reg_addr = 10'h168;
    #1;
    chk("R11 no strobe", ch_wr, 0);
    @(negedge clk);
    reg_wr = 1'b0;
    rd(10'h168, 32'h0, "R11 absent channel reads zero");
    rd(10'h3E0, 32'h0, "R11 top channel reads zero");
    idle(3);
    chk("R7 scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule